// File: doc/BRIEF.md
# SDRAM Clock-Enable Power-State Tracker

This block observes the control pins an SDRAM controller drives toward the memory on every clock: clock enable, chip select, row strobe, column strobe and write enable. It also takes a flag saying that every bank is idle. It keeps its own copy of the clock-enable level from the cycle before, so each command is read together with the clock-enable change across two cycles. From that it follows the device through three operating modes: normal operation, power-down and self-refresh. A fourth mode covers the recovery wait after a self-refresh exit.

In each cycle it classifies the command as one of the following: pass-through to the normal command decoder, entry into a low-power mode, holding that mode, exit from it, a legal wait during recovery, an illegal command, or an invalid clock-enable history. It raises an illegal flag for the last two. The action and the flag are combinational and refer to the pins of the current cycle. The mode is registered and changes at the clock edge that ends the cycle. The block suits a protocol monitor placed next to a memory controller, or an embedded sequencing check.

Top module: `sdram_cke_tracker`

## Requirements
- R1: After reset the mode is normal and the stored previous clock enable is high. Mode codes: 0 normal, 1 power-down, 2 self-refresh, 3 recovery.
- R2: In normal mode with all banks idle, a cycle where clock enable goes from high to low with chip select high (deselect) or with a NOP (chip select low; row, column and write strobes high) reports power-down entry. The mode becomes power-down at the next edge.
- R3: In normal mode with all banks idle, a high-to-low clock-enable cycle carrying the auto-refresh encoding (chip select, row and column strobes low; write strobe high) reports self-refresh entry. The mode becomes self-refresh at the next edge.
- R4: In normal mode, a high-to-low clock-enable cycle reports illegal when any bank is busy or the command is any other chip-select-low encoding. The mode stays normal.
- R5: In power-down or self-refresh, clock enable low on both cycles reports hold whatever the command pins carry. The mode does not change.
- R6: In a low-power mode, a low-to-high clock-enable cycle with deselect or NOP reports exit. Power-down returns to normal at the next edge. Self-refresh moves to recovery.
- R7: In a low-power mode, a low-to-high clock-enable cycle with any other command reports illegal, and the mode is kept.
- R8: A previous clock enable that contradicts the mode reports invalid. This means high while in power-down or self-refresh, or low while in normal or recovery.
- R9: In normal mode, clock enable high on both cycles reports pass-through with the flag low, for any command and any bank state.
- R10: Recovery lasts exactly TRC_CYCLES cycles, after which the mode returns to normal.
- R11: During recovery, deselect or NOP with clock enable high reports wait. Any other command, or clock enable low, reports illegal.
- R12: Action codes: 0 pass, 1 power-down entry, 2 self-refresh entry, 3 hold, 4 exit, 5 wait, 6 illegal, 7 invalid. The illegal flag is high exactly when the code is 6 or 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Memory interface clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cke | input | 1 | Clock enable for the current cycle |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| all_idle | input | 1 | High when every bank is idle |
| mode | output | 2 | Current operating mode (R1 codes) |
| action | output | 3 | Classification of the current cycle (R12 codes) |
| illegal | output | 1 | Illegal or invalid command this cycle |

## Verification
Action and illegal flag depend only on the pins of the present cycle and the registered state, so each is due in the same cycle the stimulus is applied. The mode reflects a command one edge later. The bench applies every stimulus at a falling edge and samples one nanosecond before the next rising edge. For each step it expects the mode held before that edge and the action for the pins just driven. Recovery length is checked by stepping through each recovery cycle and expecting normal mode on exactly the cycle after the count ends.

// File: rtl/sdram_cke_pkg.sv
package sdram_cke_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL  = 2'd0,
    MODE_PWRDN   = 2'd1,
    MODE_SELFREF = 2'd2,
    MODE_RECOVER = 2'd3
  } pwr_mode_e;

  typedef enum logic [2:0] {
    ACT_PASS     = 3'd0,
    ACT_ENTER_PD = 3'd1,
    ACT_ENTER_SR = 3'd2,
    ACT_HOLD     = 3'd3,
    ACT_EXIT     = 3'd4,
    ACT_WAIT     = 3'd5,
    ACT_ILLEGAL  = 3'd6,
    ACT_INVALID  = 3'd7
  } cke_act_e;

  typedef enum logic [1:0] {
    PIN_DESEL = 2'd0,
    PIN_NOP   = 2'd1,
    PIN_AREF  = 2'd2,
    PIN_OTHER = 2'd3
  } pin_cmd_e;

endpackage

// File: rtl/cke_cmd_decode.sv
module cke_cmd_decode
  import sdram_cke_pkg::*;
(
  input  logic     cs_n,
  input  logic     ras_n,
  input  logic     cas_n,
  input  logic     we_n,
  output pin_cmd_e cmd
);

  always_comb begin
    if (cs_n) begin
      cmd = PIN_DESEL;
    end else begin
      case ({ras_n, cas_n, we_n})
        3'b111:  cmd = PIN_NOP;
        3'b001:  cmd = PIN_AREF;
        default: cmd = PIN_OTHER;
      endcase
    end
  end

endmodule

// File: rtl/trc_timer.sv
module trc_timer #(
  parameter int TRC_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic done
);

  localparam int CW = (TRC_CYCLES < 2) ? 1 : $clog2(TRC_CYCLES + 1);
  localparam logic [CW-1:0] LOAD_VAL = CW'(TRC_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = LOAD_VAL;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/cke_mode_fsm.sv
module cke_mode_fsm
  import sdram_cke_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cke,
  input  pin_cmd_e  cmd,
  input  logic      all_idle,
  input  logic      recov_done,
  output pwr_mode_e mode,
  output cke_act_e  action,
  output logic      recov_load
);

  pwr_mode_e mode_q, mode_d;
  logic      prev_cke_q;
  logic      quiet_cmd;

  assign quiet_cmd = (cmd == PIN_DESEL) || (cmd == PIN_NOP);

  always_comb begin
    mode_d     = mode_q;
    action     = ACT_PASS;
    recov_load = 1'b0;
    case (mode_q)
      MODE_NORMAL: begin
        if (!prev_cke_q) begin
          action = ACT_INVALID;
        end else if (cke) begin
          action = ACT_PASS;
        end else if (!all_idle) begin
          action = ACT_ILLEGAL;
        end else if (quiet_cmd) begin
          action = ACT_ENTER_PD;
          mode_d = MODE_PWRDN;
        end else if (cmd == PIN_AREF) begin
          action = ACT_ENTER_SR;
          mode_d = MODE_SELFREF;
        end else begin
          action = ACT_ILLEGAL;
        end
      end
      MODE_PWRDN, MODE_SELFREF: begin
        if (prev_cke_q) begin
          action = ACT_INVALID;
        end else if (!cke) begin
          action = ACT_HOLD;
        end else if (quiet_cmd) begin
          action     = ACT_EXIT;
          recov_load = (mode_q == MODE_SELFREF);
          mode_d     = (mode_q == MODE_SELFREF) ? MODE_RECOVER : MODE_NORMAL;
        end else begin
          action = ACT_ILLEGAL;
        end
      end
      MODE_RECOVER: begin
        if (!prev_cke_q) begin
          action = ACT_INVALID;
        end else if (!cke || !quiet_cmd) begin
          action = ACT_ILLEGAL;
        end else begin
          action = ACT_WAIT;
        end
        if (recov_done) begin
          mode_d = MODE_NORMAL;
        end
      end
      default: mode_d = MODE_NORMAL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= MODE_NORMAL;
      prev_cke_q <= 1'b1;
    end else begin
      mode_q     <= mode_d;
      prev_cke_q <= cke;
    end
  end

  assign mode = mode_q;

endmodule

// File: rtl/sdram_cke_tracker.sv
module sdram_cke_tracker
  import sdram_cke_pkg::*;
#(
  parameter int TRC_CYCLES  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cke,
  input  logic       cs_n,
  input  logic       ras_n,
  input  logic       cas_n,
  input  logic       we_n,
  input  logic       all_idle,
  output logic [1:0] mode,
  output logic [2:0] action,
  output logic       illegal
);

  localparam int SS = (SYNC_STAGES < 1) ? 1 : SYNC_STAGES;

  logic [SS-1:0] rst_pipe;
  logic          rst_sync_n;

  generate
    if (SS == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_pipe <= '0;
        else        rst_pipe <= 1'b1;
      end
    end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_pipe <= '0;
        else        rst_pipe <= {rst_pipe[SS-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_sync_n = rst_pipe[SS-1];

  pin_cmd_e  cmd;
  pwr_mode_e mode_e;
  cke_act_e  act_e;
  logic      recov_load;
  logic      recov_done;

  cke_cmd_decode u_dec (
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .cmd   (cmd)
  );

  trc_timer #(.TRC_CYCLES(TRC_CYCLES)) u_trc (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .load  (recov_load),
    .done  (recov_done)
  );

  cke_mode_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .cke        (cke),
    .cmd        (cmd),
    .all_idle   (all_idle),
    .recov_done (recov_done),
    .mode       (mode_e),
    .action     (act_e),
    .recov_load (recov_load)
  );

  assign mode    = mode_e;
  assign action  = act_e;
  assign illegal = (act_e == ACT_ILLEGAL) || (act_e == ACT_INVALID);

endmodule

// File: rtl/sdram_cke_tracker_chk.sv
module sdram_cke_tracker_chk
  import sdram_cke_pkg::*;
#(
  parameter int TRC_CYCLES = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cke,
  input logic       all_idle,
  input logic [1:0] mode,
  input logic [2:0] action,
  input logic       illegal
);

  logic prev_c;
  int   rec_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_c  <= 1'b1;
      rec_cnt <= 0;
    end else begin
      prev_c  <= cke;
      rec_cnt <= (mode == MODE_RECOVER) ? rec_cnt + 1 : 0;
    end
  end

  a_r12_flag_matches: assert property (@(posedge clk) disable iff (!rst_n)
    illegal == ((action == ACT_ILLEGAL) || (action == ACT_INVALID)));

  a_r2_pd_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_NORMAL && action == ACT_ENTER_PD) |=> (mode == MODE_PWRDN));

  a_r3_sr_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_NORMAL && action == ACT_ENTER_SR) |=> (mode == MODE_SELFREF));

  a_r4_busy_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_NORMAL && prev_c && !cke && !all_idle) |-> (action == ACT_ILLEGAL));

  a_r4_busy_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_NORMAL && action == ACT_ILLEGAL) |=> (mode == MODE_NORMAL));

  a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (action == ACT_HOLD) |=> $stable(mode));

  a_r6_pd_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_PWRDN && action == ACT_EXIT) |=> (mode == MODE_NORMAL));

  a_r6_sr_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_SELFREF && action == ACT_EXIT) |=> (mode == MODE_RECOVER));

  a_r8_invalid_lowpower: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == MODE_PWRDN || mode == MODE_SELFREF) && prev_c) |-> (action == ACT_INVALID));

  a_r9_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_NORMAL && prev_c && cke) |-> (action == ACT_PASS && !illegal));

  a_r10_recover_max: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_RECOVER) |-> (rec_cnt < TRC_CYCLES));

  a_r10_recover_min: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_RECOVER && rec_cnt < TRC_CYCLES - 1) |=> (mode == MODE_RECOVER));

  a_r11_recover_action: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_RECOVER) |->
      (action == ACT_WAIT || action == ACT_ILLEGAL || action == ACT_INVALID));

endmodule

bind sdram_cke_tracker sdram_cke_tracker_chk #(.TRC_CYCLES(TRC_CYCLES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .cke      (cke),
  .all_idle (all_idle),
  .mode     (mode),
  .action   (action),
  .illegal  (illegal)
);

// File: tb/tb_sdram_cke_tracker.sv
module tb_sdram_cke_tracker;

  localparam int TRC = 4;

  localparam int M_N = 0, M_PD = 1, M_SR = 2, M_RC = 3;
  localparam int A_PASS = 0, A_EPD = 1, A_ESR = 2, A_HOLD = 3,
                 A_EXIT = 4, A_WAIT = 5, A_ILL = 6, A_INV = 7;

  localparam logic [3:0] C_DES = 4'b1111;
  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_REF = 4'b0001;
  localparam logic [3:0] C_WR  = 4'b0100;
  localparam logic [3:0] C_ACT = 4'b0011;
  localparam logic [3:0] C_PRE = 4'b0010;

  logic       clk;
  logic       rst_n;
  logic       cke, cs_n, ras_n, cas_n, we_n, all_idle;
  logic [1:0] mode;
  logic [2:0] action;
  logic       illegal;

  sdram_cke_tracker #(.TRC_CYCLES(TRC)) dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .cke      (cke),
    .cs_n     (cs_n),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .we_n     (we_n),
    .all_idle (all_idle),
    .mode     (mode),
    .action   (action),
    .illegal  (illegal)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct {
    int    emode;
    int    eact;
    int    eill;
    string req;
  } exp_t;

  exp_t q[$];
  int   n_chk;
  int   n_fail;
  bit   finished;

  task automatic report_end();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic step(input bit c, input logic [3:0] cmd, input bit idle,
                      input int em, input int ea, input string req);
    exp_t e;
    @(negedge clk);
    cke = c;
    {cs_n, ras_n, cas_n, we_n} = cmd;
    all_idle = idle;
    e.emode = em;
    e.eact  = ea;
    e.eill  = (ea == A_ILL || ea == A_INV) ? 1 : 0;
    e.req   = req;
    q.push_back(e);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #4;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_chk++;
        if (mode !== e.emode[1:0] || action !== e.eact[2:0] || illegal !== e.eill[0]) begin
          n_fail++;
          $display("FAIL %s: mode=%0d action=%0d illegal=%0d, expected mode=%0d action=%0d illegal=%0d",
                   e.req, mode, action, illegal, e.emode, e.eact, e.eill);
        end
      end
    end
  end

  initial begin
    #100000;
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: run incomplete, expected all steps done");
      report_end();
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; finished = 1'b0;
    rst_n = 1'b0;
    cke = 1'b1;
    {cs_n, ras_n, cas_n, we_n} = C_DES;
    all_idle = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset leaves mode normal with previous clock enable high
    step(0, C_DES, 1, M_N,  A_EPD,  "R1/R2 deselect entry after reset");
    step(0, C_WR,  0, M_PD, A_HOLD, "R5 hold ignores pins");
    step(1, C_NOP, 1, M_PD, A_EXIT, "R6 power-down exit");
    step(1, C_NOP, 1, M_N,  A_PASS, "R6 back to normal");
    step(1, C_WR,  0, M_N,  A_PASS, "R9 pass with busy banks");
    step(0, C_NOP, 1, M_N,  A_EPD,  "R2 NOP entry");
    step(1, C_ACT, 1, M_PD, A_ILL,  "R7 illegal exit command");
    step(1, C_NOP, 1, M_PD, A_INV,  "R8 high history in power-down");
    step(0, C_NOP, 1, M_PD, A_INV,  "R8 still high history");
    step(0, C_DES, 1, M_PD, A_HOLD, "R5 hold again");
    step(1, C_DES, 1, M_PD, A_EXIT, "R6 deselect exit");
    step(1, C_DES, 1, M_N,  A_PASS, "R9 pass");
    step(0, C_REF, 0, M_N,  A_ILL,  "R4 entry with busy bank");
    step(1, C_NOP, 1, M_N,  A_INV,  "R8 low history in normal");
    step(1, C_NOP, 1, M_N,  A_PASS, "R9 pass");
    step(0, C_PRE, 1, M_N,  A_ILL,  "R4 other command on entry");
    step(1, C_NOP, 1, M_N,  A_INV,  "R8 low history in normal");
    step(1, C_NOP, 1, M_N,  A_PASS, "R9 pass");
    step(0, C_REF, 1, M_N,  A_ESR,  "R3 self-refresh entry");
    step(0, C_ACT, 0, M_SR, A_HOLD, "R5 self-refresh hold");
    step(1, C_REF, 1, M_SR, A_ILL,  "R7 illegal self-refresh exit");
    step(0, C_DES, 1, M_SR, A_INV,  "R8 high history in self-refresh");
    step(1, C_NOP, 1, M_SR, A_EXIT, "R6 self-refresh exit");
    step(1, C_NOP, 1, M_RC, A_WAIT, "R11 wait");
    step(1, C_WR,  1, M_RC, A_ILL,  "R11 command during recovery");
    step(1, C_DES, 1, M_RC, A_WAIT, "R11 wait deselect");
    step(1, C_NOP, 1, M_RC, A_WAIT, "R10 last recovery cycle");
    step(1, C_NOP, 1, M_N,  A_PASS, "R10 normal after recovery");
    step(0, C_REF, 1, M_N,  A_ESR,  "R3 second entry");
    step(1, C_DES, 1, M_SR, A_EXIT, "R6 second exit");
    step(0, C_DES, 1, M_RC, A_ILL,  "R11 clock enable low in recovery");
    step(1, C_NOP, 1, M_RC, A_INV,  "R8 low history in recovery");
    step(1, C_NOP, 1, M_RC, A_WAIT, "R11 wait");
    step(1, C_NOP, 1, M_RC, A_WAIT, "R10 last recovery cycle");
    step(1, C_NOP, 1, M_N,  A_PASS, "R10 normal after recovery, R12 codes");

    repeat (2) @(negedge clk);
    report_end();
  end

endmodule